// File: doc/BRIEF.md
# Push-Button Power State Controller

This block decides whether the device is powered, using one active-low push-button and a few pulses from software on the serial bus. When the device is off, a press of the button turns it on. When the device is on, holding the button down for a selected hold time raises a shutdown flag that software can read. The device then turns off once a second, equally long interval has passed. Before that, software can block the shutdown with a mask bit or cancel it by clearing the flag. Software can also force the device off at once.

A single timer measures both intervals. The timer is a tick prescaler followed by a tick counter, so a bench can shrink the time base to a few cycles per tick. The button input passes through a two-flop synchronizer and then an edge register before any decision uses it.

Top module: `pwr_button_ctl`

## Requirements
- R1: After reset, `power_on` and `shdn_flag` are both 0.
- R2: While off, a high-to-low transition of `btn_n` sets `power_on` on the third rising clock edge after the input changes. A button that stays low while the device is off never turns the device on.
- R3: While on, the hold time is P = U·HALF_TICKS·TICK_DIV cycles. The button must be seen low for P consecutive cycles, and `shdn_flag` rises on rising clock edge P+2 after the press.
- R4: `hold_sel` sets U, the hold time in half-second units: 2'b00 gives U=2 (1.0 s, the default), 2'b01 gives U=3, 2'b10 gives U=4 and 2'b11 gives U=1.
- R5: If the button is released before the hold time completes, no flag is raised. The next press must then hold for a full P cycles again.
- R6: P cycles after the flag rises, `power_on` and `shdn_flag` both fall to 0. Releasing the button after the flag is set does not change this.
- R7: If `shdn_mask` is 1 when the second interval ends, the device stays on and `shdn_flag` stays 1.
- R8: A `flag_clr` pulse clears `shdn_flag` on the next edge. If the pulse arrives during the second interval, the device stays on.
- R9: A `force_off` pulse turns the device off and clears the flag on the next edge, from any state. It takes priority over a simultaneous start.
- R10: `hold_sel` is captured while the button is released or the device is off. A change during a running hold or second interval does not alter that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_n | input | 1 | Push-button, low when pressed, asynchronous |
| hold_sel | input | 2 | Hold-time code |
| shdn_mask | input | 1 | Blocks the button-driven power-off |
| force_off | input | 1 | One-cycle immediate power-off pulse |
| flag_clr | input | 1 | One-cycle flag clear pulse |
| power_on | output | 1 | Device power state |
| shdn_flag | output | 1 | Shutdown pending flag |

## Verification
The hardest case to reach is the masked expiry. The bench must hold the button through the whole first interval and then keep the mask set until the second interval has fully run out. Only then can it show that the device stays on with the flag still set. The bench shrinks the time base to twenty cycles per half-second and computes every expected transition cycle from the press time plus the synchronizer latency. It checks the cycles on both sides of each boundary. It also changes the hold code in the middle of a second interval, which shows that the captured period is kept.

// File: rtl/pwr_button_ctl.sv
module pwr_button_ctl #(
  parameter int TICK_DIV   = 1000,
  parameter int HALF_TICKS = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_n,
  input  logic [1:0] hold_sel,
  input  logic       shdn_mask,
  input  logic       force_off,
  input  logic       flag_clr,
  output logic       power_on,
  output logic       shdn_flag
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = $clog2(4 * HALF_TICKS + 1);
  localparam logic [CW-1:0] LIM1 = CW'(HALF_TICKS);
  localparam logic [CW-1:0] LIM2 = CW'(2 * HALF_TICKS);
  localparam logic [CW-1:0] LIM3 = CW'(3 * HALF_TICKS);
  localparam logic [CW-1:0] LIM4 = CW'(4 * HALF_TICKS);

  typedef enum logic [1:0] {S_OFF, S_ON, S_ARM} st_t;

  st_t st;
  logic [2:0] sync;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt, lim, lim_sel;
  logic btn_low, btn_fall, tick, done;

  assign btn_low  = ~sync[1];
  assign btn_fall = sync[2] & ~sync[1];
  assign tick     = (pre == PW'(TICK_DIV - 1));
  assign done     = tick && (cnt >= lim - 1'b1);
  assign power_on = (st != S_OFF);

  always_comb begin
    case (hold_sel)
      2'b01:   lim_sel = LIM3;
      2'b10:   lim_sel = LIM4;
      2'b11:   lim_sel = LIM1;
      default: lim_sel = LIM2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], btn_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      shdn_flag <= 1'b0;
      pre <= '0;
      cnt <= '0;
      lim <= LIM2;
    end else if (force_off) begin
      st <= S_OFF;
      shdn_flag <= 1'b0;
      pre <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF: begin
          pre <= '0;
          cnt <= '0;
          lim <= lim_sel;
          if (btn_fall) st <= S_ON;
        end
        S_ON: begin
          if (flag_clr) shdn_flag <= 1'b0;
          if (!btn_low) begin
            pre <= '0;
            cnt <= '0;
            lim <= lim_sel;
          end else if (done) begin
            pre <= '0;
            cnt <= '0;
            if (!flag_clr) begin
              st <= S_ARM;
              shdn_flag <= 1'b1;
            end
          end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick) cnt <= cnt + 1'b1;
          end
        end
        S_ARM: begin
          if (flag_clr) begin
            st <= S_ON;
            shdn_flag <= 1'b0;
            pre <= '0;
            cnt <= '0;
          end else if (done) begin
            pre <= '0;
            cnt <= '0;
            if (shdn_mask) st <= S_ON;
            else begin
              st <= S_OFF;
              shdn_flag <= 1'b0;
            end
          end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick) cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

module pwr_button_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic power_on,
  input logic shdn_flag,
  input logic force_off,
  input logic flag_clr,
  input logic shdn_mask,
  input logic btn_fall
);
  p_flag_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_flag |-> power_on);
  p_start_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_on) |-> $past(btn_fall));
  p_force_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!power_on && !shdn_flag));
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !force_off) |=> !shdn_flag);
  p_mask_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_on) |-> ($past(force_off) || !$past(shdn_mask)));
  p_flag_rise_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn_flag) |-> $past(power_on));
endmodule

bind pwr_button_ctl pwr_button_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .power_on(power_on), .shdn_flag(shdn_flag),
  .force_off(force_off), .flag_clr(flag_clr), .shdn_mask(shdn_mask),
  .btn_fall(btn_fall)
);

// File: tb/sim_pwr_button_ctl.sv
`timescale 1ns/1ps
module sim_pwr_button_ctl;
  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1;
  logic [1:0] hold_sel = 2'b00;
  logic shdn_mask = 1'b0, force_off = 1'b0, flag_clr = 1'b0;
  logic power_on, shdn_flag;

  always #2.5 clk = ~clk;

  pwr_button_ctl #(.TICK_DIV(4), .HALF_TICKS(5)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .hold_sel(hold_sel),
    .shdn_mask(shdn_mask), .force_off(force_off), .flag_clr(flag_clr),
    .power_on(power_on), .shdn_flag(shdn_flag)
  );

  typedef struct { int cyc; bit pwr; bit flg; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, base = 0, n_chk = 0, n_fail = 0;
  bit done_run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      n_chk++;
      if (q[0].cyc < cyc) begin
        n_fail++;
        $display("FAIL %s: check for cycle %0d missed at %0d", q[0].tag, q[0].cyc, cyc);
      end else if (power_on !== q[0].pwr || shdn_flag !== q[0].flg) begin
        n_fail++;
        $display("FAIL %s: cycle %0d pwr/flag actual %b/%b expected %b/%b",
                 q[0].tag, cyc, power_on, shdn_flag, q[0].pwr, q[0].flg);
      end
      void'(q.pop_front());
    end
  end

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask
  task automatic mark();
    base = cyc;
  endtask
  task automatic expect_at(int off, bit p, bit f, string t);
    exp_t e;
    e.cyc = base + off; e.pwr = p; e.flg = f; e.tag = t;
    q.push_back(e);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    mark(); expect_at(1, 0, 0, "R1");
    wait_n(5);
    // start from off, hold to flag, release, off after second period
    mark(); btn_n = 0;
    expect_at(2, 0, 0, "R2"); expect_at(3, 1, 0, "R2");
    expect_at(42, 1, 0, "R3"); expect_at(43, 1, 1, "R3");
    expect_at(82, 1, 1, "R6"); expect_at(83, 0, 0, "R6");
    wait_n(50); btn_n = 1; wait_n(40);
    // early release, then full hold; level low while off does not start
    mark(); btn_n = 0; expect_at(3, 1, 0, "R2");
    wait_n(10); btn_n = 1;
    expect_at(45, 1, 0, "R5");
    wait_n(50);
    mark(); btn_n = 0;
    expect_at(41, 1, 0, "R5"); expect_at(42, 1, 1, "R5");
    expect_at(81, 1, 1, "R6"); expect_at(82, 0, 0, "R6");
    expect_at(100, 0, 0, "R2");
    wait_n(105); btn_n = 1; wait_n(10);
    // mask blocks the power-off
    mark(); shdn_mask = 1; btn_n = 0; expect_at(3, 1, 0, "R2");
    wait_n(6); btn_n = 1; wait_n(14);
    mark(); btn_n = 0;
    expect_at(42, 1, 1, "R3"); expect_at(82, 1, 1, "R7"); expect_at(90, 1, 1, "R7");
    wait_n(85); btn_n = 1; wait_n(10);
    mark(); flag_clr = 1; expect_at(1, 1, 0, "R8");
    wait_n(1); flag_clr = 0; wait_n(10); shdn_mask = 0;
    // flag clear cancels pending off
    mark(); btn_n = 0;
    expect_at(42, 1, 1, "R3"); expect_at(51, 1, 0, "R8"); expect_at(90, 1, 0, "R8");
    wait_n(45); btn_n = 1; wait_n(5); flag_clr = 1; wait_n(1); flag_clr = 0;
    wait_n(45);
    // code 11 hold, code change mid-interval ignored
    hold_sel = 2'b11; wait_n(5);
    mark(); btn_n = 0;
    expect_at(21, 1, 0, "R4"); expect_at(22, 1, 1, "R4");
    expect_at(41, 1, 1, "R10"); expect_at(42, 0, 0, "R10");
    wait_n(25); hold_sel = 2'b10; btn_n = 1; wait_n(25);
    // code 10 from off, then force off while armed
    mark(); btn_n = 0; expect_at(3, 1, 0, "R2");
    expect_at(82, 1, 0, "R4"); expect_at(83, 1, 1, "R4");
    wait_n(85); btn_n = 1; wait_n(5);
    mark(); force_off = 1; expect_at(1, 0, 0, "R9"); expect_at(80, 0, 0, "R9");
    wait_n(1); force_off = 0; wait_n(85);
    // force off wins over a simultaneous start
    mark(); btn_n = 0; expect_at(3, 0, 0, "R9"); expect_at(10, 0, 0, "R9");
    wait_n(2); force_off = 1; wait_n(1); force_off = 0; wait_n(9); btn_n = 1; wait_n(5);
    // force off from plain on state
    mark(); btn_n = 0; expect_at(3, 1, 0, "R2"); expect_at(21, 0, 0, "R9");
    wait_n(5); btn_n = 1; wait_n(15); force_off = 1; wait_n(1); force_off = 0;
    wait_n(10);
    wait (q.size() == 0);
    wait_n(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule